// File: doc/BRIEF.md
# Three-Address Instruction Cycle Sequencer

This block is the control sequencer of a small three-address machine with a 1024-word memory. For every instruction it runs the same fixed cycle of six equal periods. It waits for the arithmetic unit to report completion and writes that result to memory. It then reads the next command word, reads both operands, and launches the arithmetic unit on them. A 10-bit program counter selects the command. A 40-bit command register holds the order code and three addresses. A 10-bit register keeps the counter value from before the step, for use by neighbouring logic.

Every period lasts `CLKS_PER_PERIOD` clocks, which must be at least 2. Memory accesses use one strobe on the first clock of their period. Read data is taken on the last clock of the same period. After reset there is no result yet, so the first cycle goes straight from the opening period to the command read and skips the write-back.

Top module: `tas_sequencer`

## Requirements
- R1: While reset is held, `mem_re`, `mem_we` and `au_start` are low, and `pc_o` and `k_o` are zero.
- R2: In the first cycle after reset, no write-back happens. The first memory access is a read of address 0.
- R3: Each later instruction performs, in this order: a write to the result address, a command read at the program counter, a read at the first operand address, a read at the second operand address, and then a start. The command word layout is: order code in bits 39:30, first operand address in bits 29:20, second operand address in bits 19:10, result address in bits 9:0.
- R4: Successive steps from write-back to start lie exactly `CLKS_PER_PERIOD` clocks apart. Each strobe is high for one clock only, at the first clock of its period.
- R5: Memory read data is valid from the clock after the strobe until the period ends. At the start pulse, `au_order` equals the order field of the fetched command, and `au_opa`/`au_opb` equal the memory words read from the two operand addresses.
- R6: After the command read, the program counter advances by one, wrapping from 1023 to 0. `k_o` then holds the value the counter had before the step.
- R7: The sequencer stays in period 1 until `au_done` is seen. The write-back occurs at the first period boundary after the clock on which `au_done` is high, which is 1 to `CLKS_PER_PERIOD` clocks later.
- R8: The written data equals the `au_result` presented with `au_done` during period 1. An `au_done` pulse in any other period changes neither the written data nor the timing.
- R9: `au_start` pulses for one clock exactly once per instruction. At most one of `mem_re`, `mem_we` and `au_start` is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 10 | Memory word address |
| mem_re | output | 1 | Read strobe, one clock |
| mem_we | output | 1 | Write strobe, one clock |
| mem_wdata | output | 40 | Write data (captured result) |
| mem_rdata | input | 40 | Read data, valid from the clock after `mem_re` |
| au_start | output | 1 | Launch pulse to the arithmetic unit |
| au_order | output | 10 | Order code of the current command |
| au_opa | output | 40 | First operand |
| au_opb | output | 40 | Second operand |
| au_done | input | 1 | Completion pulse from the arithmetic unit |
| au_result | input | 40 | Result, valid with `au_done` |
| pc_o | output | 10 | Program counter |
| k_o | output | 10 | Saved pre-step counter value |

## Verification
The bench runs more than a thousand instructions out of a memory filled with random words. The command fields therefore point anywhere, including at commands that are still to be fetched. This tells a correct write-before-fetch order apart from a swapped one, and it walks the counter through its wrap. The arithmetic unit answers after a random delay of one to several periods, which separates waiting for a real completion from advancing at a fixed period count. Spurious `au_done` pulses with garbage results are placed in the write and read periods to show that only the period-1 completion is captured. A directed first command whose result address is 1 checks that a write-back is seen by the very next fetch.

// File: rtl/tas_pkg.sv
package tas_pkg;

    localparam int FIELD_W = 10;
    localparam int NFIELDS = 4;
    localparam int WORD_W  = FIELD_W * NFIELDS;
    localparam int NOPND   = 2;

    typedef logic [FIELD_W-1:0] field_t;
    typedef logic [WORD_W-1:0]  word_t;

    // Command layout, most significant field first.
    typedef struct packed {
        field_t order;
        field_t src_a;
        field_t src_b;
        field_t dest;
    } cmd_t;

    typedef enum logic [2:0] {
        PH_ACK    = 3'd0,
        PH_STORE  = 3'd1,
        PH_FETCH  = 3'd2,
        PH_LOAD_A = 3'd3,
        PH_LOAD_B = 3'd4,
        PH_LAUNCH = 3'd5
    } phase_e;

endpackage

// File: rtl/tas_period_timer.sv
module tas_period_timer #(
    parameter int CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic first_o,
    output logic last_o
);

    localparam int CW = (CLKS > 1) ? $clog2(CLKS) : 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(CLKS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_s;

    tmr_s tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.cnt == LAST_CNT) begin
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign first_o = (tmr_q.cnt == '0);
    assign last_o  = (tmr_q.cnt == LAST_CNT);

endmodule

// File: rtl/tas_phase_ctrl.sv
module tas_phase_ctrl
    import tas_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tick_last,
    input  logic   au_done,
    output phase_e phase_o,
    output logic   capture_o
);

    typedef struct packed {
        phase_e phase;
        logic   boot;
        logic   done_seen;
    } ctl_s;

    localparam ctl_s CTL_RESET = '{phase: PH_ACK, boot: 1'b1, done_seen: 1'b0};

    ctl_s ctl_d, ctl_q;

    always_comb begin
        ctl_d     = ctl_q;
        capture_o = 1'b0;
        unique case (ctl_q.phase)
            PH_ACK: begin
                // Completion only counts here, and never in the boot pass.
                if (!ctl_q.boot && au_done) begin
                    ctl_d.done_seen = 1'b1;
                    capture_o       = 1'b1;
                end
                if (tick_last) begin
                    if (ctl_q.boot) begin
                        ctl_d.boot  = 1'b0;
                        ctl_d.phase = PH_FETCH;
                    end else if (ctl_q.done_seen || au_done) begin
                        ctl_d.done_seen = 1'b0;
                        ctl_d.phase     = PH_STORE;
                    end
                end
            end
            PH_STORE:  if (tick_last) ctl_d.phase = PH_FETCH;
            PH_FETCH:  if (tick_last) ctl_d.phase = PH_LOAD_A;
            PH_LOAD_A: if (tick_last) ctl_d.phase = PH_LOAD_B;
            PH_LOAD_B: if (tick_last) ctl_d.phase = PH_LAUNCH;
            PH_LAUNCH: if (tick_last) ctl_d.phase = PH_ACK;
            default:   ctl_d = CTL_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= CTL_RESET;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign phase_o = ctl_q.phase;

endmodule

// File: rtl/tas_datapath.sv
module tas_datapath
    import tas_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_e phase,
    input  logic   tick_first,
    input  logic   tick_last,
    input  logic   capture,
    input  word_t  mem_rdata,
    input  word_t  au_result,
    output field_t mem_addr,
    output logic   mem_re,
    output logic   mem_we,
    output word_t  mem_wdata,
    output logic   au_start,
    output field_t au_order,
    output word_t  au_opa,
    output word_t  au_opb,
    output field_t pc_o,
    output field_t k_o
);

    typedef struct packed {
        field_t                  pc;
        field_t                  k;
        cmd_t                    cmd;
        word_t                   res;
        logic [NOPND-1:0][WORD_W-1:0] opnd;
    } dp_s;

    dp_s dp_d, dp_q;

    logic [NOPND-1:0] opnd_load;

    for (genvar g = 0; g < NOPND; g++) begin : g_opnd_sel
        localparam phase_e LOAD_PH = (g == 0) ? PH_LOAD_A : PH_LOAD_B;
        assign opnd_load[g] = tick_last && (phase == LOAD_PH);
    end

    always_comb begin
        dp_d = dp_q;
        if (capture) begin
            dp_d.res = au_result;
        end
        if (tick_last && (phase == PH_FETCH)) begin
            dp_d.cmd = cmd_t'(mem_rdata);
            dp_d.k   = dp_q.pc;
            dp_d.pc  = dp_q.pc + 1'b1;
        end
        for (int i = 0; i < NOPND; i++) begin
            if (opnd_load[i]) begin
                dp_d.opnd[i] = mem_rdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    always_comb begin
        unique case (phase)
            PH_FETCH:  mem_addr = dp_q.pc;
            PH_LOAD_A: mem_addr = dp_q.cmd.src_a;
            PH_LOAD_B: mem_addr = dp_q.cmd.src_b;
            default:   mem_addr = dp_q.cmd.dest;
        endcase
        mem_re   = tick_first && ((phase == PH_FETCH) || (phase == PH_LOAD_A) ||
                                  (phase == PH_LOAD_B));
        mem_we   = tick_first && (phase == PH_STORE);
        au_start = tick_first && (phase == PH_LAUNCH);
    end

    assign mem_wdata = dp_q.res;
    assign au_order  = dp_q.cmd.order;
    assign au_opa    = dp_q.opnd[0];
    assign au_opb    = dp_q.opnd[1];
    assign pc_o      = dp_q.pc;
    assign k_o       = dp_q.k;

endmodule

// File: rtl/tas_sequencer.sv
module tas_sequencer
    import tas_pkg::*;
#(
    parameter int CLKS_PER_PERIOD = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    output logic [tas_pkg::FIELD_W-1:0] mem_addr,
    output logic                        mem_re,
    output logic                        mem_we,
    output logic [tas_pkg::WORD_W-1:0]  mem_wdata,
    input  logic [tas_pkg::WORD_W-1:0]  mem_rdata,
    output logic                        au_start,
    output logic [tas_pkg::FIELD_W-1:0] au_order,
    output logic [tas_pkg::WORD_W-1:0]  au_opa,
    output logic [tas_pkg::WORD_W-1:0]  au_opb,
    input  logic                        au_done,
    input  logic [tas_pkg::WORD_W-1:0]  au_result,
    output logic [tas_pkg::FIELD_W-1:0] pc_o,
    output logic [tas_pkg::FIELD_W-1:0] k_o
);

    logic   tick_first;
    logic   tick_last;
    logic   capture;
    phase_e phase;

    tas_period_timer #(
        .CLKS (CLKS_PER_PERIOD)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .first_o (tick_first),
        .last_o  (tick_last)
    );

    tas_phase_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_last (tick_last),
        .au_done   (au_done),
        .phase_o   (phase),
        .capture_o (capture)
    );

    tas_datapath u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .tick_first (tick_first),
        .tick_last  (tick_last),
        .capture    (capture),
        .mem_rdata  (mem_rdata),
        .au_result  (au_result),
        .mem_addr   (mem_addr),
        .mem_re     (mem_re),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata),
        .au_start   (au_start),
        .au_order   (au_order),
        .au_opa     (au_opa),
        .au_opb     (au_opb),
        .pc_o       (pc_o),
        .k_o        (k_o)
    );

endmodule

// File: rtl/tas_sequencer_checker.sv
module tas_sequencer_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       mem_re,
    input logic       mem_we,
    input logic       au_start,
    input logic [9:0] pc_o,
    input logic [9:0] k_o
);

    // R9: launch pulse lasts one clock
    a_r9_start_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        au_start |=> !au_start);

    // R4: read strobe lasts one clock
    a_r4_read_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> !mem_re);

    // R4: write strobe lasts one clock
    a_r4_write_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R9: strobes never overlap
    a_r9_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_re, mem_we, au_start}));

    // R6: counter only moves by one, modulo the address space
    a_r6_pc_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pc_o) |-> (pc_o == $past(pc_o) + 10'd1));

    // R6: saved register takes the pre-step counter value
    a_r6_k_holds_old_pc: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pc_o) |-> (k_o == $past(pc_o)));

endmodule

bind tas_sequencer tas_sequencer_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_re   (mem_re),
    .mem_we   (mem_we),
    .au_start (au_start),
    .pc_o     (pc_o),
    .k_o      (k_o)
);

// File: tb/tas_sequencer_tb.sv
module tas_sequencer_tb;

    localparam int C      = 4;
    localparam int N_INSN = 1030;
    localparam int K_WR   = 1;
    localparam int K_RD   = 2;
    localparam int K_ST   = 3;

    typedef struct {
        int          kind;
        int          cyc;
        int          done_at;
        logic [9:0]  addr;
        logic [39:0] data;
        logic [9:0]  order;
        logic [39:0] a;
        logic [39:0] b;
        logic [9:0]  pc;
        logic [9:0]  k;
    } ev_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [9:0]  mem_addr;
    logic        mem_re;
    logic        mem_we;
    logic [39:0] mem_wdata;
    logic [39:0] mem_rdata;
    logic        au_start;
    logic [9:0]  au_order;
    logic [39:0] au_opa;
    logic [39:0] au_opb;
    logic        au_done;
    logic [39:0] au_result;
    logic [9:0]  pc_o;
    logic [9:0]  k_o;

    logic [39:0] mem     [1024];
    logic [39:0] ref_mem [1024];
    ev_t         ev_q [$];

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    tas_sequencer #(
        .CLKS_PER_PERIOD (C)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_re    (mem_re),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .au_start  (au_start),
        .au_order  (au_order),
        .au_opa    (au_opa),
        .au_opb    (au_opb),
        .au_done   (au_done),
        .au_result (au_result),
        .pc_o      (pc_o),
        .k_o       (k_o)
    );

    function automatic logic [39:0] alu_f(logic [9:0] op, logic [39:0] x, logic [39:0] y);
        case (op[1:0])
            2'd0:    return x + y;
            2'd1:    return x - y;
            2'd2:    return x ^ y;
            default: return {x[19:0], y[19:0]};
        endcase
    endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic get_ev(output ev_t e);
        while (ev_q.size() == 0) @(negedge clk);
        e = ev_q.pop_front();
    endtask

    // Memory, arithmetic unit and monitor, all acting away from the rising edge.
    initial begin
        bit          pend = 0;
        int          due = 0;
        int          done_cyc = 0;
        logic [39:0] pres = '0;
        au_done   = 1'b0;
        au_result = '0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            cyc++;
            if (rst_n === 1'b1) begin
                if (mem_we || mem_re || au_start) begin
                    ev_t e;
                    e.kind    = mem_we ? K_WR : (mem_re ? K_RD : K_ST);
                    e.cyc     = cyc;
                    e.done_at = done_cyc;
                    e.addr    = mem_addr;
                    e.data    = mem_wdata;
                    e.order   = au_order;
                    e.a       = au_opa;
                    e.b       = au_opb;
                    e.pc      = pc_o;
                    e.k       = k_o;
                    ev_q.push_back(e);
                end
                if (mem_we) mem[mem_addr] = mem_wdata;
                if (mem_re) mem_rdata = mem[mem_addr];
                au_done   = 1'b0;
                au_result = {$urandom(), $urandom()};
                if (au_start) begin
                    pend = 1;
                    due  = cyc + int'($urandom_range(C, 4 * C + 2));
                    pres = alu_f(au_order, au_opa, au_opb);
                end else if (pend && cyc == due) begin
                    au_done   = 1'b1;
                    au_result = pres;
                    pend      = 0;
                    done_cyc  = cyc;
                end else if ((mem_re || mem_we) && $urandom_range(0, 2) == 0) begin
                    au_done = 1'b1;   // stray pulse with a garbage result
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        ev_t         e;
        logic [9:0]  pc_e = '0;
        logic [39:0] cmd;
        logic [9:0]  prev_w = '0;
        logic [39:0] prev_res = '0;
        int          t_start = 0;
        int          t_prev = 0;
        bit          have_prev = 0;

        void'($urandom(32'd2024));
        rst_n = 1'b0;
        for (int i = 0; i < 1024; i++) begin
            logic [39:0] v;
            v = {$urandom(), $urandom()};
            mem[i]     = v;
            ref_mem[i] = v;
        end
        // Directed: first result lands on the next command address.
        mem[0][9:0]     = 10'd1;
        ref_mem[0][9:0] = 10'd1;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "reset mem_re", 64'(mem_re), 64'd0);
        chk("R1", "reset mem_we", 64'(mem_we), 64'd0);
        chk("R1", "reset au_start", 64'(au_start), 64'd0);
        chk("R1", "reset pc_o", 64'(pc_o), 64'd0);
        chk("R1", "reset k_o", 64'(k_o), 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < N_INSN; i++) begin
            if (have_prev) begin
                int ack0;
                int exp_t;
                get_ev(e);
                ack0  = t_start + C;
                exp_t = ack0 + ((e.done_at - ack0) / C + 1) * C;
                chk("R3", "write-back kind", 64'(e.kind), 64'(K_WR));
                chk("R3", "write-back address", 64'(e.addr), 64'(prev_w));
                chk("R8", "write-back data", 64'(e.data), 64'(prev_res));
                chk("R7", "write-back cycle", 64'(e.cyc), 64'(exp_t));
                ref_mem[prev_w] = prev_res;
                t_prev = e.cyc;
            end
            get_ev(e);
            chk(i == 0 ? "R2" : "R3", "fetch kind", 64'(e.kind), 64'(K_RD));
            chk(i == 0 ? "R2" : "R3", "fetch address", 64'(e.addr), 64'(pc_e));
            if (have_prev) chk("R4", "fetch spacing", 64'(e.cyc - t_prev), 64'(C));
            cmd    = ref_mem[pc_e];
            t_prev = e.cyc;

            get_ev(e);
            chk("R3", "operand A kind", 64'(e.kind), 64'(K_RD));
            chk("R3", "operand A address", 64'(e.addr), 64'(cmd[29:20]));
            chk("R4", "operand A spacing", 64'(e.cyc - t_prev), 64'(C));
            chk("R6", "pc after fetch", 64'(e.pc), 64'(10'(pc_e + 10'd1)));
            chk("R6", "k after fetch", 64'(e.k), 64'(pc_e));
            t_prev = e.cyc;

            get_ev(e);
            chk("R3", "operand B kind", 64'(e.kind), 64'(K_RD));
            chk("R3", "operand B address", 64'(e.addr), 64'(cmd[19:10]));
            chk("R4", "operand B spacing", 64'(e.cyc - t_prev), 64'(C));
            t_prev = e.cyc;

            get_ev(e);
            chk("R9", "start kind", 64'(e.kind), 64'(K_ST));
            chk("R4", "start spacing", 64'(e.cyc - t_prev), 64'(C));
            chk("R5", "order code", 64'(e.order), 64'(cmd[39:30]));
            chk("R5", "operand A value", 64'(e.a), 64'(ref_mem[cmd[29:20]]));
            chk("R5", "operand B value", 64'(e.b), 64'(ref_mem[cmd[19:10]]));
            t_start   = e.cyc;
            prev_w    = cmd[9:0];
            prev_res  = alu_f(cmd[39:30], ref_mem[cmd[29:20]], ref_mem[cmd[19:10]]);
            pc_e      = pc_e + 10'd1;
            have_prev = 1;
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule